// File: doc/BRIEF.md
# Nibble Accumulator ALU with Decimal Mode

This block is the arithmetic and logic stage of a small accumulator machine whose data path is built from 4-bit digits. Each cycle it takes the accumulator value, a memory operand, the incoming carry, overflow and decimal-mode flags, and a 3-bit operation code. One clock edge later it presents the result digit(s) with freshly computed Zero, Negative, Carry and oVerflow flags. The surrounding core holds the accumulator and flag registers, decodes instructions and performs memory accesses. It writes this block's registered outputs back to its own state.

The block supports eight operations: bitwise NOT, bitwise AND, add with carry, subtract with borrow, add the carry alone, subtract the borrow alone, and rotates left and right by one bit through the carry. There is no separate shift operation, because shifts are built from the rotates. When the decimal-mode flag is set, all four add and subtract operations work in packed BCD, correcting each digit and rippling the decimal carry between digits. The number of digits is a parameter, with a default of one, so the default data path is 4 bits wide.

Top module: `nib_alu`

## Requirements
- R1: Op code 0 (NOT) returns the bitwise inverse of the accumulator, and op code 1 (AND) returns accumulator AND memory operand. For both, carry and overflow out equal the incoming carry and overflow flags, and the decimal-mode flag has no effect.
- R2: For every operation, Zero out is 1 exactly when the result is all zeros, and Negative out equals the most significant result bit.
- R3: Op code 2 (add with carry) in binary mode returns acc + mem + C modulo 2^W. C out is the carry out of the top bit, and V out is set when the signed two's-complement sum does not fit in W bits.
- R4: Op code 3 (subtract with borrow) in binary mode returns acc - mem - C modulo 2^W. C out is 1 when the true difference is below zero (borrow), and V out is set when the signed difference does not fit in W bits.
- R5: Op code 4 (carry-only add) and op code 5 (borrow-only subtract) behave as op codes 2 and 3 with a memory operand of zero. The memory operand has no effect on their results or flags.
- R6: In decimal mode (D=1), addition works digit by digit from the least significant 4-bit digit. When a digit sum including the incoming decimal carry exceeds 9, 6 is added to it, its low 4 bits are kept, and a carry passes to the next digit. The carry out of the top digit is C out.
- R7: In decimal mode, subtraction works digit by digit. When a digit difference including the incoming borrow is below zero, 6 is subtracted from its low 4 bits and a borrow passes to the next digit. The borrow out of the top digit is C out.
- R8: In decimal mode, V out of add and subtract operations equals the signed overflow of the same operation carried out in binary.
- R9: Op code 6 (rotate left) returns {acc[W-2:0], C}, and C out becomes acc[W-1]. The decimal-mode flag has no effect.
- R10: Op code 7 (rotate right) returns {C, acc[W-1:1]}, and C out becomes acc[0]. The decimal-mode flag has no effect.
- R11: For both rotates, V out equals the new top result bit XOR the new C out.
- R12: All outputs are registered, with one clock of latency. While rst_ni is low, the result is 0, Zero is 1, and Negative, Carry and oVerflow are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code (0 NOT, 1 AND, 2 add with carry, 3 subtract with borrow, 4 carry-only add, 5 borrow-only subtract, 6 rotate left, 7 rotate right) |
| acc_i | input | 4*DIGITS | Accumulator operand |
| mem_i | input | 4*DIGITS | Memory operand |
| flag_c_i | input | 1 | Incoming carry / borrow flag |
| flag_v_i | input | 1 | Incoming overflow flag |
| flag_d_i | input | 1 | Decimal-mode flag |
| res_o | output | 4*DIGITS | Registered result |
| z_o | output | 1 | Zero flag out |
| n_o | output | 1 | Negative flag out |
| c_o | output | 1 | Carry / borrow flag out |
| v_o | output | 1 | Overflow flag out |

## Verification
Several properties are checked on every clocked cycle: the Zero and Negative flags agree with the registered result, logic operations pass C and V through, both rotates produce the expected bit movement and V rule, a binary add matches a full-width sum, and a decimal add of valid digits never leaves a digit above 9. The digit corrections in decimal mode, the borrow sense of subtraction, the operand masking of the carry-only and borrow-only operations, and overflow in decimal mode are shown only by the bench. It sweeps every operation over all operand pairs, both incoming carry values and both modes, and compares each result against an independent model. Directed cases pin down the decimal wrap-arounds 9+1 and 0-1.

// File: rtl/nib_alu_pkg.sv
`timescale 1ns/1ps
package nib_alu_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam int unsigned OP_W    = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOT = 3'd0,
    OP_AND = 3'd1,
    OP_ADC = 3'd2,
    OP_SBB = 3'd3,
    OP_CAR = 3'd4,
    OP_BOW = 3'd5,
    OP_RCL = 3'd6,
    OP_RCR = 3'd7
  } nib_op_e;
endpackage

// File: rtl/nib_logic_unit.sv
`timescale 1ns/1ps
module nib_logic_unit #(
  parameter int unsigned W = 4
) (
  input  logic         inv_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  assign res_o = inv_i ? ~a_i : (a_i & b_i);
endmodule

// File: rtl/nib_rotate_unit.sv
`timescale 1ns/1ps
module nib_rotate_unit #(
  parameter int unsigned W = 4
) (
  input  logic         right_i,
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         v_o
);
  always_comb begin
    if (right_i) begin
      res_o = {cin_i, a_i[W-1:1]};
      c_o   = a_i[0];
    end else begin
      res_o = {a_i[W-2:0], cin_i};
      c_o   = a_i[W-1];
    end
    v_o = res_o[W-1] ^ c_o;
  end
endmodule

// File: rtl/nib_addsub_unit.sv
`timescale 1ns/1ps
module nib_addsub_unit #(
  parameter int unsigned DIGITS = 1
) (
  input  logic                                   sub_i,
  input  logic                                   dec_i,
  input  logic [DIGITS*nib_alu_pkg::DIGIT_W-1:0] a_i,
  input  logic [DIGITS*nib_alu_pkg::DIGIT_W-1:0] b_i,
  input  logic                                   cin_i,
  output logic [DIGITS*nib_alu_pkg::DIGIT_W-1:0] res_o,
  output logic                                   c_o,
  output logic                                   v_o
);
  localparam int unsigned DW = nib_alu_pkg::DIGIT_W;
  localparam int unsigned W  = DIGITS * DW;
  localparam int unsigned M  = W - 1;

  logic [W:0]   bin_sum;
  logic         bin_v;
  logic [W-1:0] dec_res;
  logic         dec_c [DIGITS+1];

  // binary path; also supplies V in decimal mode
  always_comb begin
    if (sub_i) begin
      bin_sum = {1'b0, a_i} - {1'b0, b_i} - {{W{1'b0}}, cin_i};
      bin_v   = (a_i[M] != b_i[M]) && (bin_sum[M] != a_i[M]);
    end else begin
      bin_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
      bin_v   = (a_i[M] == b_i[M]) && (bin_sum[M] != a_i[M]);
    end
  end

  assign dec_c[0] = cin_i;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    logic [DW:0]   raw;
    logic [DW-1:0] fix;
    logic          cout;

    always_comb begin
      if (sub_i) begin
        raw  = {1'b0, a_i[g*DW +: DW]} - {1'b0, b_i[g*DW +: DW]} - {{DW{1'b0}}, dec_c[g]};
        cout = raw[DW];
        fix  = cout ? (raw[DW-1:0] - DW'(6)) : raw[DW-1:0];
      end else begin
        raw  = {1'b0, a_i[g*DW +: DW]} + {1'b0, b_i[g*DW +: DW]} + {{DW{1'b0}}, dec_c[g]};
        cout = (raw > (DW+1)'(9));
        fix  = cout ? (raw[DW-1:0] + DW'(6)) : raw[DW-1:0];
      end
    end

    assign dec_res[g*DW +: DW] = fix;
    assign dec_c[g+1]          = cout;
  end

  assign res_o = dec_i ? dec_res : bin_sum[W-1:0];
  assign c_o   = dec_i ? dec_c[DIGITS] : bin_sum[W];
  assign v_o   = bin_v;
endmodule

// File: rtl/nib_alu.sv
`timescale 1ns/1ps
module nib_alu #(
  parameter int unsigned DIGITS = 1
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [nib_alu_pkg::OP_W-1:0]           op_i,
  input  logic [DIGITS*nib_alu_pkg::DIGIT_W-1:0] acc_i,
  input  logic [DIGITS*nib_alu_pkg::DIGIT_W-1:0] mem_i,
  input  logic                                   flag_c_i,
  input  logic                                   flag_v_i,
  input  logic                                   flag_d_i,
  output logic [DIGITS*nib_alu_pkg::DIGIT_W-1:0] res_o,
  output logic                                   z_o,
  output logic                                   n_o,
  output logic                                   c_o,
  output logic                                   v_o
);
  import nib_alu_pkg::*;

  localparam int unsigned W = DIGITS * DIGIT_W;

  nib_op_e      op;
  logic [W-1:0] lu_res, as_res, rot_res, as_b, nxt_res;
  logic         as_sub, as_c, as_v, rot_c, rot_v, nxt_c, nxt_v;

  assign op     = nib_op_e'(op_i);
  assign as_sub = (op == OP_SBB) || (op == OP_BOW);
  assign as_b   = ((op == OP_CAR) || (op == OP_BOW)) ? '0 : mem_i;

  nib_logic_unit #(.W(W)) i_logic (
    .inv_i (op == OP_NOT),
    .a_i   (acc_i),
    .b_i   (mem_i),
    .res_o (lu_res)
  );

  nib_addsub_unit #(.DIGITS(DIGITS)) i_addsub (
    .sub_i (as_sub),
    .dec_i (flag_d_i),
    .a_i   (acc_i),
    .b_i   (as_b),
    .cin_i (flag_c_i),
    .res_o (as_res),
    .c_o   (as_c),
    .v_o   (as_v)
  );

  nib_rotate_unit #(.W(W)) i_rotate (
    .right_i (op == OP_RCR),
    .a_i     (acc_i),
    .cin_i   (flag_c_i),
    .res_o   (rot_res),
    .c_o     (rot_c),
    .v_o     (rot_v)
  );

  always_comb begin
    nxt_res = lu_res;
    nxt_c   = flag_c_i;
    nxt_v   = flag_v_i;
    unique case (op)
      OP_NOT, OP_AND: ;
      OP_ADC, OP_SBB, OP_CAR, OP_BOW: begin
        nxt_res = as_res;
        nxt_c   = as_c;
        nxt_v   = as_v;
      end
      OP_RCL, OP_RCR: begin
        nxt_res = rot_res;
        nxt_c   = rot_c;
        nxt_v   = rot_v;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o <= '0;
      z_o   <= 1'b1;
      n_o   <= 1'b0;
      c_o   <= 1'b0;
      v_o   <= 1'b0;
    end else begin
      res_o <= nxt_res;
      z_o   <= (nxt_res == '0);
      n_o   <= nxt_res[W-1];
      c_o   <= nxt_c;
      v_o   <= nxt_v;
    end
  end
endmodule

// File: rtl/nib_alu_chk.sv
`timescale 1ns/1ps
module nib_alu_chk #(
  parameter int unsigned DIGITS = 1
) (
  input logic                                   clk_i,
  input logic                                   rst_ni,
  input logic [nib_alu_pkg::OP_W-1:0]           op_i,
  input logic [DIGITS*nib_alu_pkg::DIGIT_W-1:0] acc_i,
  input logic [DIGITS*nib_alu_pkg::DIGIT_W-1:0] mem_i,
  input logic                                   flag_c_i,
  input logic                                   flag_v_i,
  input logic                                   flag_d_i,
  input logic [DIGITS*nib_alu_pkg::DIGIT_W-1:0] res_o,
  input logic                                   z_o,
  input logic                                   n_o,
  input logic                                   c_o,
  input logic                                   v_o
);
  localparam int unsigned W = DIGITS * nib_alu_pkg::DIGIT_W;

  logic is_logic, is_rcl, is_rcr, is_badd, is_dadd_ok;
  assign is_logic   = (op_i == 3'd0) || (op_i == 3'd1);
  assign is_rcl     = (op_i == 3'd6);
  assign is_rcr     = (op_i == 3'd7);
  assign is_badd    = (op_i == 3'd2) && !flag_d_i;
  assign is_dadd_ok = ((op_i == 3'd2) || (op_i == 3'd4)) && flag_d_i
                      && (acc_i[3:0] <= 4'd9) && (mem_i[3:0] <= 4'd9);

  p_zero_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    z_o == (res_o == '0));

  p_neg_flag_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    n_o == res_o[W-1]);

  p_logic_keeps_cv_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_logic |=> (c_o == $past(flag_c_i)) && (v_o == $past(flag_v_i)));

  p_bin_add_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_badd |=> {c_o, res_o} == ($past({1'b0, acc_i}) + $past({1'b0, mem_i})
                                 + $past({{W{1'b0}}, flag_c_i})));

  p_dec_digit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_dadd_ok |=> res_o[3:0] <= 4'd9);

  p_rcl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rcl |=> (res_o == {$past(acc_i[W-2:0]), $past(flag_c_i)}) && (c_o == $past(acc_i[W-1])));

  p_rcr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_rcr |=> (res_o == {$past(flag_c_i), $past(acc_i[W-1:1])}) && (c_o == $past(acc_i[0])));

  p_rot_v_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_rcl || is_rcr) |=> v_o == (res_o[W-1] ^ c_o));
endmodule

bind nib_alu nib_alu_chk #(.DIGITS(DIGITS)) i_nib_alu_chk (.*);

// File: tb/test_nib_alu.sv
`timescale 1ns/1ps
module test_nib_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op = '0;
  logic [3:0] acc = '0, mem = '0;
  logic       fc = 1'b0, fv = 1'b0, fd = 1'b0;
  logic [3:0] res;
  logic       z, n, c, v;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    logic [7:0] exp;   // {res, z, n, c, v}
    string      req;
    string      stim;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  nib_alu #(.DIGITS(1)) i_nib_alu (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .acc_i(acc), .mem_i(mem),
    .flag_c_i(fc), .flag_v_i(fv), .flag_d_i(fd),
    .res_o(res), .z_o(z), .n_o(n), .c_o(c), .v_o(v)
  );

  function automatic int sx(int x);
    return (x > 7) ? x - 16 : x;
  endfunction

  // independent reference built from R1..R11
  function automatic logic [7:0] model(int o, int a, int b, int ci, int vi, int d);
    int r, co, vo, t, s, bb;
    co = ci; vo = vi; r = 0;
    bb = (o == 4 || o == 5) ? 0 : b;     // R5 operand masking
    case (o)
      0: r = (~a) & 15;
      1: r = a & b;
      2, 4: begin
        t = a + bb + ci;
        if (d != 0) begin co = (t > 9) ? 1 : 0; r = (co != 0) ? (t + 6) & 15 : t; end
        else begin co = (t > 15) ? 1 : 0; r = t & 15; end
        s = sx(a) + sx(bb) + ci;          // R8 binary overflow
        vo = (s > 7 || s < -8) ? 1 : 0;
      end
      3, 5: begin
        t = a - bb - ci;
        co = (t < 0) ? 1 : 0;
        if (d != 0) r = (co != 0) ? (t + 26) & 15 : t;
        else r = (t + 16) & 15;
        s = sx(a) - sx(bb) - ci;
        vo = (s > 7 || s < -8) ? 1 : 0;
      end
      6: begin r = ((a << 1) | ci) & 15; co = (a >> 3) & 1; vo = ((r >> 3) & 1) ^ co; end
      default: begin r = (ci << 3) | (a >> 1); co = a & 1; vo = ((r >> 3) & 1) ^ co; end
    endcase
    return {4'(r), (r == 0), 1'((r >> 3) & 1), 1'(co), 1'(vo)};
  endfunction

  function automatic string req_of(int o, int d);
    case (o)
      0, 1:    return "R1/R2";
      2:       return (d != 0) ? "R6/R8/R2" : "R3/R2";
      3:       return (d != 0) ? "R7/R8/R2" : "R4/R2";
      4, 5:    return "R5/R2";
      6:       return "R9/R11/R2";
      default: return "R10/R11/R2";
    endcase
  endfunction

  task automatic drive(int o, int a, int b, int ci, int vi, int d);
    item_t it;
    @(negedge clk);
    op = 3'(o); acc = 4'(a); mem = 4'(b); fc = 1'(ci); fv = 1'(vi); fd = 1'(d);
    it.exp  = model(o, a, b, ci, vi, d);
    it.req  = req_of(o, d);
    it.stim = $sformatf("op=%0d a=%h b=%h c=%0d v=%0d d=%0d", o, a, b, ci, vi, d);
    sb_q.push_back(it);
  endtask

  // monitor: one clock of latency (R12)
  always @(posedge clk) begin
    item_t it;
    #1;
    if (rst_n && sb_q.size() > 0) begin
      it = sb_q.pop_front();
      n_checks++;
      if ({res, z, n, c, v} !== it.exp) begin
        n_fail++;
        $display("FAIL %s (R12 latency) %s: got res=%h znvc=%b%b%b%b exp res=%h znvc=%b%b%b%b",
                 it.req, it.stim, res, z, n, v, c,
                 it.exp[7:4], it.exp[3], it.exp[2], it.exp[0], it.exp[1]);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R12 reset state
    repeat (3) @(negedge clk);
    n_checks++;
    if ({res, z, n, c, v} !== 8'b0000_1000) begin
      n_fail++;
      $display("FAIL R12 reset: got %h%b%b%b%b exp 0 1000", res, z, n, c, v);
    end
    rst_n = 1'b1;

    // directed corners
    drive(0, 15, 0, 1, 1, 1);   // R1 NOT to zero, C/V passed, D ignored
    drive(1, 12, 10, 0, 1, 0);  // R1 AND
    drive(2, 7, 1, 0, 0, 0);    // R3 signed overflow
    drive(2, 15, 1, 0, 0, 0);   // R3 carry out, zero
    drive(2, 5, 7, 0, 0, 1);    // R6 5+7 -> 2, C
    drive(2, 9, 9, 1, 0, 1);    // R6 9+9+1 -> 9, C
    drive(3, 3, 5, 0, 0, 0);    // R4 borrow
    drive(3, 3, 5, 0, 0, 1);    // R7 3-5 -> 8, borrow
    drive(4, 15, 9, 1, 0, 0);   // R5 carry-only wraps, mem ignored
    drive(4, 9, 3, 1, 0, 1);    // R5/R6 9+1 decimal -> 0
    drive(5, 0, 7, 1, 0, 1);    // R5/R7 0-1 decimal -> 9
    drive(6, 8, 0, 0, 0, 0);    // R9 rotate left into carry
    drive(7, 1, 0, 1, 0, 1);    // R10 rotate right
    // sweep all ops, operands, carry and mode
    for (int d = 0; d < 2; d++)
      for (int o = 0; o < 8; o++)
        for (int a = 0; a < 16; a++)
          for (int b = 0; b < 16; b++)
            for (int ci = 0; ci < 2; ci++)
              drive(o, a, b, ci, (a ^ b) & 1, d);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule